// File: doc/BRIEF.md
# Serial Register Port with Address Pointer

This block is a two-wire serial slave that gives a bus master read and write access to a small bank of byte registers. It has no select input. The serial clock and the shared, open-drain data line alone mark where each transfer starts and stops. Both lines are sampled on the system clock through a short synchronizer. Start, stop and clock edges are found from the synchronized samples. The slave pulls the data line low through `sda_oe` when it acknowledges or sends a zero bit.

A transfer begins with a device byte. Its upper six bits must be a fixed prefix, and the next bit must equal the level on the strap input. The final bit selects the direction. In a write, the first byte after the device byte loads an address pointer, and any further bytes are stored into the register the pointer selects. In a read, the slave returns the register the pointer selects. A flag inside the pointer byte makes the pointer step forward after each byte, which allows burst access. One register reflects an external status byte. Two bits of another register reflect external flags. Bus writes cannot change any of these read-only bits.

Top module: `i2c_regport`

## Requirements
- R1: The slave acknowledges a device byte only when its bits [7:2] equal 001000 and bit [1] equals `addr_strap`. For any other device byte it gives no acknowledge and leaves the data line released until the next start or stop.
- R2: Bit [0] of the device byte is the direction: 0 selects a write and 1 selects a read.
- R3: In a write, the first byte after the device byte loads the pointer. Bits [2:0] give the register index, bit [7] enables auto-increment, and bits [6:3] are ignored.
- R4: Each later byte of a write is stored into the register at the pointer index. With auto-increment clear, every byte goes to the same register. `reg_out` (register k in bits [8k+7:8k]) changes only through such stores.
- R5: With auto-increment set, the pointer steps forward by one after each stored byte and wraps from 7 to 0.
- R6: A read sends the register at the pointer MSB first and releases the line during the master's acknowledge slot. With auto-increment set, the pointer steps forward after each byte sent. A not-acknowledge from the master ends the burst, and the pointer then selects the register after the last one sent.
- R7: The slave pulls the data line low in the acknowledge slot after a matching device byte, after the pointer byte and after each written byte. It changes its drive only while the clock is low.
- R8: Register 6 reads back as `stat_in`. Writes to it have no effect, and it appears as zero in `reg_out`.
- R9: In register 1, bit 7 reads as `clk_err_in` and bit 6 reads as `cal_pend_in`. Writes cannot change these two bits, and they appear as zero in `reg_out`. Bits [5:0] are ordinary read/write bits.
- R10: The pointer keeps its value across transfers. A write that carries only the pointer byte, followed by a repeated start and a read, returns the selected register.
- R11: After reset every register is zero and the line is released. A start at any point abandons the current byte and begins a new device byte. A stop returns the slave to idle, and a partly received data byte is never stored.

FSM states: IDLE (bus free), ADDR (shift in device byte), ADDR_ACK, PTR (shift in pointer byte), PTR_ACK, WDATA (shift in data byte), WDATA_ACK, RDATA (shift out data byte), RACK (master acknowledge slot), IGNORE (not addressed, or read ended). Transitions: a stop goes from any state to IDLE, and a start goes from any state to ADDR. ADDR goes to ADDR_ACK on a match and to IGNORE otherwise. ADDR_ACK goes to PTR for a write and to RDATA for a read. PTR goes to PTR_ACK and then to WDATA. WDATA and WDATA_ACK alternate. RDATA goes to RACK. RACK goes back to RDATA on an acknowledge and to IGNORE on a not-acknowledge. Every byte-state exit happens on the clock fall after its eighth bit, and every acknowledge-state exit happens on the next clock fall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Data line level as seen on the bus |
| sda_oe | output | 1 | 1 pulls the data line low |
| addr_strap | input | 1 | Level that device address bit [1] must match |
| stat_in | input | 8 | External status byte shown as register 6 |
| clk_err_in | input | 1 | External flag shown as register 1 bit 7 |
| cal_pend_in | input | 1 | External flag shown as register 1 bit 6 |
| reg_out | output | 64 | Stored register contents, register k in bits [8k+7:8k] |

## Verification
A wrong pointer shows up in the first byte read after it. Either the data differs, or `reg_out` changes in the wrong byte lane as soon as the write's eighth clock fall is seen through the synchronizer. A state machine stuck in the wrong phase shows up within one byte time as a missing or extra acknowledge. It can also show up as the line being held low when the master expects it released. A lost read-only mask shows at once in `reg_out` after a write of ones to register 1 or 6. The bench keeps its own model of the registers and the pointer, and compares every acknowledge and every returned byte against it.

// File: rtl/i2c_regport_pkg.sv
package i2c_regport_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_PTR,
        ST_PTR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK,
        ST_IGNORE
    } port_state_t;

    localparam logic [5:0] DEV_PREFIX = 6'b001000;
    localparam logic [3:0] BYTE_BITS  = 4'd8;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [SYNC_STAGES-1:0] scl_pipe, sda_pipe;
    logic scl_q, sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_i};
            scl_q    <= scl_pipe[SYNC_STAGES-1];
            sda_q    <= sda_pipe[SYNC_STAGES-1];
        end
    end

    assign scl_s     = scl_pipe[SYNC_STAGES-1];
    assign sda_s     = sda_pipe[SYNC_STAGES-1];
    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    assign start_det = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_regport_fsm.sv
module i2c_regport_fsm
    import i2c_regport_pkg::*;
#(
    parameter int NREG = 8,
    localparam int IW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_rise,
    input  logic          scl_fall,
    input  logic          sda_s,
    input  logic          start_det,
    input  logic          stop_det,
    input  logic          addr_strap,
    input  logic [7:0]    rd_data,
    output logic [IW-1:0] rd_idx,
    output logic          wr_en,
    output logic [IW-1:0] wr_idx,
    output logic [7:0]    wr_data,
    output logic          sda_oe,
    output port_state_t   state_o
);
    port_state_t state, nxt;
    logic [7:0]    shreg, txreg;
    logic [3:0]    cnt;
    logic          rw, m_nack, ptr_inc;
    logic [IW-1:0] ptr_idx;
    logic          byte_done, addr_hit;

    assign byte_done = scl_fall && (cnt == BYTE_BITS);
    assign addr_hit  = (shreg[7:1] == {DEV_PREFIX, addr_strap});
    assign rd_idx    = ptr_idx;
    assign wr_idx    = ptr_idx;
    assign wr_data   = shreg;
    assign wr_en     = (state == ST_WDATA) && byte_done && !start_det && !stop_det;
    assign state_o   = state;

    // next-state logic
    always_comb begin
        nxt = state;
        if (stop_det) begin
            nxt = ST_IDLE;
        end else if (start_det) begin
            nxt = ST_ADDR;
        end else begin
            unique case (state)
                ST_IDLE:      nxt = ST_IDLE;
                ST_ADDR:      if (byte_done) nxt = addr_hit ? ST_ADDR_ACK : ST_IGNORE;
                ST_ADDR_ACK:  if (scl_fall)  nxt = rw ? ST_RDATA : ST_PTR;
                ST_PTR:       if (byte_done) nxt = ST_PTR_ACK;
                ST_PTR_ACK:   if (scl_fall)  nxt = ST_WDATA;
                ST_WDATA:     if (byte_done) nxt = ST_WDATA_ACK;
                ST_WDATA_ACK: if (scl_fall)  nxt = ST_WDATA;
                ST_RDATA:     if (byte_done) nxt = ST_RACK;
                ST_RACK:      if (scl_fall)  nxt = m_nack ? ST_IGNORE : ST_RDATA;
                ST_IGNORE:    nxt = ST_IGNORE;
                default:      nxt = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // shift, count and pointer datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg   <= '0;
            txreg   <= '0;
            cnt     <= '0;
            rw      <= 1'b0;
            m_nack  <= 1'b1;
            ptr_idx <= '0;
            ptr_inc <= 1'b0;
        end else if (start_det || stop_det) begin
            cnt <= '0;
        end else begin
            if (scl_rise) begin
                unique case (state)
                    ST_ADDR, ST_PTR, ST_WDATA: begin
                        shreg <= {shreg[6:0], sda_s};
                        cnt   <= cnt + 4'd1;
                    end
                    ST_RDATA: cnt    <= cnt + 4'd1;
                    ST_RACK:  m_nack <= sda_s;
                    default: ;
                endcase
            end
            if (scl_fall) begin
                unique case (state)
                    ST_ADDR: if (byte_done) begin
                        rw  <= shreg[0];
                        cnt <= '0;
                    end
                    ST_ADDR_ACK: begin
                        cnt <= '0;
                        if (rw) txreg <= rd_data;
                    end
                    ST_PTR: if (byte_done) begin
                        ptr_idx <= shreg[IW-1:0];
                        ptr_inc <= shreg[7];
                        cnt     <= '0;
                    end
                    ST_WDATA: if (byte_done) begin
                        cnt <= '0;
                        if (ptr_inc) ptr_idx <= ptr_idx + 1'b1;
                    end
                    ST_RDATA: begin
                        if (byte_done) begin
                            cnt <= '0;
                            if (ptr_inc) ptr_idx <= ptr_idx + 1'b1;
                        end else begin
                            txreg <= {txreg[6:0], 1'b0};
                        end
                    end
                    ST_RACK: if (!m_nack) txreg <= rd_data;
                    default: ;
                endcase
            end
        end
    end

    // data-line drive, updated only on clock falls or bus conditions
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sda_oe <= 1'b0;
        end else if (start_det || stop_det) begin
            sda_oe <= 1'b0;
        end else if (scl_fall) begin
            unique case (state)
                ST_ADDR:          sda_oe <= byte_done && addr_hit;
                ST_PTR, ST_WDATA: sda_oe <= byte_done;
                ST_ADDR_ACK:      sda_oe <= rw && !rd_data[7];
                ST_RDATA:         sda_oe <= byte_done ? 1'b0 : !txreg[6];
                ST_RACK:          sda_oe <= !m_nack && !rd_data[7];
                default:          sda_oe <= 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/i2c_regport_regs.sv
module i2c_regport_regs #(
    parameter int NREG     = 8,
    parameter int STAT_IDX = 6,
    parameter int CTRL_IDX = 1,
    parameter int ERR_BIT  = 7,
    parameter int CAL_BIT  = 6,
    localparam int IW      = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IW-1:0]     wr_idx,
    input  logic [7:0]        wr_data,
    input  logic [IW-1:0]     rd_idx,
    input  logic [7:0]        stat_in,
    input  logic              clk_err_in,
    input  logic              cal_pend_in,
    output logic [7:0]        rd_data,
    output logic [NREG*8-1:0] reg_out
);
    localparam logic [7:0] RO_MASK = (8'h01 << ERR_BIT) | (8'h01 << CAL_BIT);

    logic [7:0] ro_flags;
    logic [NREG-1:0][7:0] view;

    always_comb begin
        ro_flags          = '0;
        ro_flags[ERR_BIT] = clk_err_in;
        ro_flags[CAL_BIT] = cal_pend_in;
    end

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        localparam logic [7:0] WMASK = (g == STAT_IDX) ? 8'h00 :
                                       (g == CTRL_IDX) ? ~RO_MASK : 8'hFF;
        logic [7:0] q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                            q <= '0;
            else if (wr_en && wr_idx == IW'(g))    q <= wr_data & WMASK;
        end

        if (g == STAT_IDX) begin : g_stat
            assign view[g] = stat_in;
        end else if (g == CTRL_IDX) begin : g_ctrl
            assign view[g] = q | ro_flags;
        end else begin : g_plain
            assign view[g] = q;
        end

        assign reg_out[g*8 +: 8] = q;
    end

    assign rd_data = view[rd_idx];
endmodule

// File: rtl/i2c_regport.sv
module i2c_regport
    import i2c_regport_pkg::*;
#(
    parameter int NREG        = 8,
    parameter int STAT_IDX    = 6,
    parameter int CTRL_IDX    = 1,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic              addr_strap,
    input  logic [7:0]        stat_in,
    input  logic              clk_err_in,
    input  logic              cal_pend_in,
    output logic [NREG*8-1:0] reg_out
);
    localparam int IW = $clog2(NREG);

    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic          wr_en;
    logic [IW-1:0] wr_idx, rd_idx;
    logic [7:0]    wr_data, rd_data;
    port_state_t   fsm_state;

    i2c_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    i2c_regport_fsm #(.NREG(NREG)) u_fsm (
        .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .sda_s(sda_s), .start_det(start_det), .stop_det(stop_det),
        .addr_strap(addr_strap), .rd_data(rd_data), .rd_idx(rd_idx),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .sda_oe(sda_oe), .state_o(fsm_state)
    );

    i2c_regport_regs #(.NREG(NREG), .STAT_IDX(STAT_IDX), .CTRL_IDX(CTRL_IDX)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .rd_idx(rd_idx), .stat_in(stat_in), .clk_err_in(clk_err_in),
        .cal_pend_in(cal_pend_in), .rd_data(rd_data), .reg_out(reg_out)
    );
endmodule

// File: rtl/i2c_regport_chk.sv
module i2c_regport_chk
    import i2c_regport_pkg::*;
#(
    parameter int NREG     = 8,
    parameter int STAT_IDX = 6,
    localparam int IW      = $clog2(NREG)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scl_s,
    input logic              sda_oe,
    input port_state_t       state,
    input logic              wr_en,
    input logic [IW-1:0]     wr_idx,
    input logic [NREG*8-1:0] reg_out
);
    // R11
    idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE || state == ST_IGNORE) |-> !sda_oe);

    // R7
    drive_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_s);

    // R4
    reg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(reg_out));

    // R8
    stat_wr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx == IW'(STAT_IDX)) |=> $stable(reg_out));

    // R7
    wr_then_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (state == ST_WDATA_ACK));
endmodule

bind i2c_regport i2c_regport_chk #(.NREG(NREG), .STAT_IDX(STAT_IDX)) u_chk (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_oe(sda_oe), .state(fsm_state),
    .wr_en(wr_en), .wr_idx(wr_idx), .reg_out(reg_out)
);

// File: tb/sim_i2c_regport.sv
module sim_i2c_regport;
    localparam int Q = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic strap = 1'b1;
    logic [7:0] stat = 8'h00;
    logic cerr = 1'b0, cpend = 1'b0;
    logic sda_oe;
    logic [63:0] reg_out;
    wire  sda_bus = sda_m & ~sda_oe;

    int n_chk = 0, n_fail = 0;
    logic [7:0] mq [8];
    logic [2:0] mptr = '0;
    logic       minc = 1'b0;

    always #2.5 clk = ~clk;

    i2c_regport u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe),
        .addr_strap(strap), .stat_in(stat), .clk_err_in(cerr), .cal_pend_in(cpend),
        .reg_out(reg_out)
    );

    function automatic logic [7:0] view(input logic [2:0] i);
        if (i == 3'd6) return stat;
        if (i == 3'd1) return mq[1] | {cerr, cpend, 6'b0};
        return mq[i];
    endfunction

    function automatic logic [7:0] wmask(input logic [2:0] i);
        if (i == 3'd6) return 8'h00;
        if (i == 3'd1) return 8'h3F;
        return 8'hFF;
    endfunction

    function automatic logic [63:0] flat();
        logic [63:0] f;
        for (int k = 0; k < 8; k++) f[k*8 +: 8] = mq[k];
        return f;
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic hold();
        repeat (Q) @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        sda_m = b; hold(); scl_m = 1'b1; hold(); hold(); scl_m = 1'b0;
    endtask

    task automatic start_c();
        sda_m = 1'b1; hold(); scl_m = 1'b1; hold(); sda_m = 1'b0; hold(); scl_m = 1'b0; hold();
    endtask

    task automatic stop_c();
        sda_m = 1'b0; hold(); scl_m = 1'b1; hold(); sda_m = 1'b1; hold(); hold();
    endtask

    task automatic wr_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        sda_m = 1'b1; hold(); scl_m = 1'b1; hold();
        ack = !sda_bus;
        hold(); scl_m = 1'b0;
    endtask

    task automatic rd_byte(input logic nack, output logic [7:0] d);
        for (int i = 7; i >= 0; i--) begin
            sda_m = 1'b1; hold(); scl_m = 1'b1; hold();
            d[i] = sda_bus;
            hold(); scl_m = 1'b0;
        end
        send_bit(nack);
    endtask

    function automatic logic [7:0] dev(input logic rd);
        return {6'b001000, strap, rd};
    endfunction

    // write: pointer byte then n data bytes (n may be 0)
    task automatic do_write(input logic [7:0] pb, input int n, input logic [31:0] data);
        logic ack;
        start_c();
        wr_byte(dev(1'b0), ack); chk("R1 write addr ack", ack, 1);
        wr_byte(pb, ack);        chk("R7 pointer ack", ack, 1);
        mptr = pb[2:0]; minc = pb[7];   // R3
        for (int k = 0; k < n; k++) begin
            wr_byte(data[k*8 +: 8], ack);
            chk("R7 data ack", ack, 1);
            mq[mptr] = data[k*8 +: 8] & wmask(mptr);
            if (minc) mptr = mptr + 1'b1;
        end
        stop_c();
        chk("R4 reg_out after write", reg_out, flat());
    endtask

    task automatic read_body(input int n, input string req);
        logic ack;
        logic [7:0] d;
        wr_byte(dev(1'b1), ack); chk("R2 read addr ack", ack, 1);
        for (int k = 0; k < n; k++) begin
            rd_byte(k == n - 1, d);
            chk(req, d, view(mptr));
            if (minc) mptr = mptr + 1'b1;
        end
        stop_c();
        chk("R6 line released after read", sda_oe, 0);
    endtask

    task automatic do_read(input int n, input string req);
        start_c();
        read_body(n, req);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic ack;
        void'($urandom(32'd1234));
        for (int k = 0; k < 8; k++) mq[k] = 8'h00;
        repeat (4) @(negedge clk);
        // R11 reset state
        chk("R11 reset oe", sda_oe, 0);
        chk("R11 reset regs", reg_out, 64'h0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R4 fixed pointer
        do_write(8'h02, 3, 32'h00_33_22_11);
        chk("R4 last byte kept", reg_out[23:16], 8'h33);
        // R5 increment and wrap
        do_write(8'h83, 3, 32'h00_C5_B4_A3);
        do_write(8'h87, 2, 32'h0000_0F_E7);
        chk("R5 wrap to reg0", reg_out[7:0], 8'h0F);
        // R8 status protected
        stat = 8'h5A;
        do_write(8'h06, 1, 32'hFF);
        chk("R8 status not stored", reg_out[55:48], 8'h00);
        do_read(1, "R8 status reads stat_in");
        // R9 read-only flags
        cerr = 1'b1; cpend = 1'b0;
        do_write(8'h01, 1, 32'hFF);
        chk("R9 flag bits not stored", reg_out[15:8], 8'h3F);
        do_read(1, "R9 flags read back");
        cerr = 1'b0; cpend = 1'b1;
        do_read(1, "R9 flags read back");
        // R1 wrong strap and wrong prefix
        strap = 1'b0;
        start_c(); wr_byte(8'b0010_0010, ack); chk("R1 strap mismatch nack", ack, 0);
        wr_byte(8'h85, ack); chk("R1 ignored byte nack", ack, 0);
        stop_c(); chk("R1 regs untouched", reg_out, flat());
        start_c(); wr_byte(8'b0110_0000, ack); chk("R1 prefix mismatch nack", ack, 0); stop_c();
        // R10 pointer-only write, repeated start, read burst
        do_write(8'h83, 0, 32'h0);
        do_read(1, "R10 pointer persists");
        start_c(); wr_byte(dev(1'b0), ack); wr_byte(8'h82, ack);
        mptr = 3'd2; minc = 1'b1;
        start_c(); read_body(4, "R6 burst read");
        do_read(1, "R6 pointer after nack");
        // R11 start in mid byte abandons it
        start_c(); wr_byte(dev(1'b0), ack); wr_byte(8'h04, ack);
        mptr = 3'd4; minc = 1'b0;
        for (int i = 0; i < 4; i++) send_bit(1'b1);
        start_c(); wr_byte(dev(1'b0), ack); chk("R11 restart ack", ack, 1);
        stop_c();
        chk("R11 partial byte dropped", reg_out, flat());
        do_read(1, "R11 pointer intact");

        // random mix
        for (int t = 0; t < 40; t++) begin
            logic [7:0] pb;
            pb = 8'($urandom);
            stat = 8'($urandom); cerr = 1'($urandom); cpend = 1'($urandom);
            if ($urandom % 2) do_write(pb, 1 + int'($urandom % 4), $urandom);
            else begin
                do_write(pb, 0, 32'h0);
                do_read(1 + int'($urandom % 4), "R6 random read");
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule